// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block moves the bits of an 8-bit or 16-bit operand left or right and reports the bit that falls off through a carry output. Seven behaviours are offered: plain left shift, logical right shift, and arithmetic right shift. It also offers rotation in either direction, and rotation in either direction through the carry bit. In the through-carry rotations the incoming carry works as one more bit in the circular path. The amount is either a fixed single position or an 8-bit count supplied by a counter register elsewhere in the datapath.

A single-position request, or a count of zero, finishes in the cycle after `start`. A larger count moves one position per clock while `busy` is high. After that, `done` is high for one cycle. Results and flags are held until the next accepted request. Overflow, sign, zero and parity are kept as state. A request that does not define a flag leaves that flag as it was, so the surrounding datapath can take the flag outputs as its current condition bits.

Top module: `srot_unit`

## Requirements
- R1: Operation codes 4 and 6 both move every bit one place toward the MSB per step, put 0 in the LSB and send the previous MSB to `carry_out`.
- R2: Operation code 5 moves every bit one place toward the LSB per step, puts 0 in the MSB and sends the previous LSB to `carry_out`.
- R3: Operation code 7 moves every bit one place toward the LSB per step, keeps the previous MSB in the MSB and sends the previous LSB to `carry_out`.
- R4: Operation code 0 rotates toward the MSB, copying the previous MSB to both the LSB and `carry_out`. Operation code 1 rotates toward the LSB, copying the previous LSB to both the MSB and `carry_out`.
- R5: Operation code 2 rotates toward the MSB through the carry: the previous carry enters the LSB and the previous MSB becomes the carry. Operation code 3 does the same toward the LSB: the previous carry enters the MSB and the previous LSB becomes the carry.
- R6: When `wide` is 0 only operand bits 7..0 take part, bit 7 serves as the MSB, and `result[15:8]` is 0. When `wide` is 1 all 16 bits take part.
- R7: With `use_count` at 0 the amount is one position. With `use_count` at 1 it is `count_val`, and the result equals that many single-position steps, counts above the width included.
- R8: For an amount n of 0 or 1, `done` is high in the first cycle after the start cycle. For n of 2 or more, `busy` is high in cycles 1 to n-1 after the start cycle and `done` is high in cycle n.
- R9: `done` lasts one cycle. A `start` while `busy` is high is ignored. A `start` in the cycle in which `done` is high is accepted.
- R10: A count of zero gives `result` equal to the width-masked operand and `carry_out` equal to `carry_in`. It leaves `overflow`, `sign`, `zero` and `parity` unchanged.
- R11: For an amount of one, `overflow` becomes the XOR of the MSB of the result and the MSB of the operand, for every operation. For an amount of two or more, `overflow` becomes 0.
- R12: After a shift (codes 4 to 7) with a non-zero amount, the flags are set as follows. `sign` is the result MSB. `zero` is 1 when the masked result is 0. `parity` is 1 when `result[7:0]` holds an even number of ones. Rotates (codes 0 to 3) leave these three flags unchanged.
- R13: While `rst_n` is low, `result`, `carry_out`, `overflow`, `sign`, `zero`, `parity`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted when `busy` is low |
| op | input | 3 | Operation code (see R1 to R5) |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| use_count | input | 1 | 1 = amount from `count_val`, 0 = amount of one |
| count_val | input | 8 | Amount from the count register |
| operand | input | 16 | Value to shift or rotate |
| carry_in | input | 1 | Current carry flag |
| busy | output | 1 | Multi-step operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted or rotated value |
| carry_out | output | 1 | New carry flag |
| overflow | output | 1 | Overflow flag |
| sign | output | 1 | Sign flag |
| zero | output | 1 | Zero flag |
| parity | output | 1 | Even-parity flag of the low byte |

## Verification
Two events can share a cycle: the completion pulse of one request and the acceptance of the next. The bench drives every following request in the very cycle that `done` is high. It then checks that the new request runs for exactly its own latency and produces its own result, while the flags left by the previous request are carried across as expected. A second overlap occurs when a conflicting `start` lands in the middle of a multi-step request. It carries a changed operand, code, count and carry. It is judged by comparing the final result, carry and cycle count against the untouched request.

// File: rtl/srot_pkg.sv
package srot_pkg;

  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAL = 3'd6,
    OP_SAR = 3'd7
  } srot_op_e;

  // Shifts define sign/zero/parity; rotates do not.
  function automatic logic srot_is_shift(input srot_op_e op);
    return op inside {OP_SHL, OP_SHR, OP_SAL, OP_SAR};
  endfunction

  // Amount that a request asks for: fixed one or the count register.
  function automatic logic [7:0] srot_amount(input logic use_cnt, input logic [7:0] cnt);
    return use_cnt ? cnt : 8'd1;
  endfunction

endpackage

// File: rtl/srot_step.sv
module srot_step
  import srot_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] val,
  input  logic          cin,
  input  srot_op_e      op,
  input  logic          wide,
  output logic [DW-1:0] nval,
  output logic          cout,
  output logic          msb_in,
  output logic          msb_out
);
  localparam int HW = DW / 2;
  localparam int UW = DW - HW;
  localparam logic [DW-1:0] TOP_W  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] TOP_B  = {{UW{1'b0}}, 1'b1, {(HW-1){1'b0}}};
  localparam logic [DW-1:0] MASK_B = {{UW{1'b0}}, {HW{1'b1}}};

  logic [DW-1:0] lane_mask;
  logic [DW-1:0] top_bit;
  logic [DW-1:0] left_v;
  logic [DW-1:0] right_v;
  logic [DW-1:0] raw;
  logic          lsb;

  assign lane_mask = wide ? {DW{1'b1}} : MASK_B;
  assign top_bit   = wide ? TOP_W : TOP_B;
  assign msb_in    = wide ? val[DW-1] : val[HW-1];
  assign lsb       = val[0];
  assign left_v    = val << 1;
  assign right_v   = val >> 1;

  always_comb begin
    raw  = left_v;
    cout = msb_in;
    case (op)
      OP_ROL: begin
        raw  = left_v | {{(DW-1){1'b0}}, msb_in};
        cout = msb_in;
      end
      OP_ROR: begin
        raw  = right_v | (lsb ? top_bit : '0);
        cout = lsb;
      end
      OP_RCL: begin
        raw  = left_v | {{(DW-1){1'b0}}, cin};
        cout = msb_in;
      end
      OP_RCR: begin
        raw  = right_v | (cin ? top_bit : '0);
        cout = lsb;
      end
      OP_SHL, OP_SAL: begin
        raw  = left_v;
        cout = msb_in;
      end
      OP_SHR: begin
        raw  = right_v;
        cout = lsb;
      end
      OP_SAR: begin
        raw  = right_v | (msb_in ? top_bit : '0);
        cout = lsb;
      end
      default: begin
        raw  = left_v;
        cout = msb_in;
      end
    endcase
  end

  assign nval    = raw & lane_mask;
  assign msb_out = wide ? nval[DW-1] : nval[HW-1];

endmodule

// File: rtl/srot_seq.sv
module srot_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  output logic             accept,
  output logic             zero_cnt,
  output logic             single,
  output logic             fin,
  output logic             busy,
  output logic             done
);
  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] rem_q;
  logic             short_req;
  logic             last_step;

  assign accept    = start && !busy_q;
  assign short_req = (cnt <= CNT_W'(1));
  assign zero_cnt  = accept && (cnt == '0);
  assign single    = accept && (cnt == CNT_W'(1));
  assign last_step = busy_q && (rem_q == CNT_W'(1));
  assign fin       = (accept && short_req) || last_step;
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      done_q <= fin;
      if (accept && !short_req) begin
        busy_q <= 1'b1;
        rem_q  <= cnt - CNT_W'(1);
      end else if (busy_q) begin
        rem_q <= rem_q - CNT_W'(1);
        if (last_step) busy_q <= 1'b0;
      end
    end
  end

  AST_SHORT_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && short_req |=> done && !busy); // R8
  AST_LONG_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !short_req |=> busy && !done); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !last_step |=> busy && (rem_q == $past(rem_q) - CNT_W'(1))); // R9

endmodule

// File: rtl/srot_flags.sv
module srot_flags #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin,
  input  logic          zero_cnt,
  input  logic          single,
  input  logic          shift_op,
  input  logic          msb_old,
  input  logic          msb_new,
  input  logic [DW-1:0] res,
  output logic          overflow,
  output logic          sign,
  output logic          zero,
  output logic          parity
);
  localparam int HW = DW / 2;

  logic ov_q, sg_q, zr_q, pa_q;
  logic even_ones;
  logic upd;

  function automatic logic even_parity(input logic [HW-1:0] b);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < HW; i++) acc = acc ^ b[i];
    return acc;
  endfunction

  assign even_ones = even_parity(res[HW-1:0]);
  assign upd       = fin && !zero_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      sg_q <= 1'b0;
      zr_q <= 1'b0;
      pa_q <= 1'b0;
    end else if (upd) begin
      ov_q <= single ? (msb_new ^ msb_old) : 1'b0;
      if (shift_op) begin
        sg_q <= msb_new;
        zr_q <= (res == '0);
        pa_q <= even_ones;
      end
    end
  end

  assign overflow = ov_q;
  assign sign     = sg_q;
  assign zero     = zr_q;
  assign parity   = pa_q;

  AST_ROTATE_KEEPS_SZP: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !shift_op |=> $stable({sign, zero, parity})); // R12
  AST_MULTI_CLEARS_OV: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !single && !zero_cnt |=> !overflow); // R11
  AST_ZERO_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fin && zero_cnt |=> $stable({overflow, sign, zero, parity})); // R10

endmodule

// File: rtl/srot_unit.sv
module srot_unit
  import srot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic              use_count,
  input  logic [CNT_W-1:0]  count_val,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              overflow,
  output logic              sign,
  output logic              zero,
  output logic              parity
);
  localparam int HALF_W = DATA_W / 2;
  localparam int UPPER_W = DATA_W - HALF_W;

  srot_op_e          op_in;
  srot_op_e          op_q;
  logic              wide_q;
  logic [DATA_W-1:0] work_q;
  logic              cy_q;

  logic [CNT_W-1:0]  amount;
  logic [DATA_W-1:0] opnd_m;
  logic              accept, zero_cnt, single, fin;

  logic [DATA_W-1:0] st_val, st_next;
  logic              st_cin, st_cout, st_wide;
  srot_op_e          st_op;
  logic              msb_old, msb_new;

  assign op_in  = srot_op_e'(op);
  assign amount = use_count ? count_val : CNT_W'(1);
  assign opnd_m = wide ? operand : {{UPPER_W{1'b0}}, operand[HALF_W-1:0]};

  srot_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cnt      (amount),
    .accept   (accept),
    .zero_cnt (zero_cnt),
    .single   (single),
    .fin      (fin),
    .busy     (busy),
    .done     (done)
  );

  // The first step works on the incoming operand, later ones on the held value.
  assign st_val  = accept ? opnd_m   : work_q;
  assign st_cin  = accept ? carry_in : cy_q;
  assign st_op   = accept ? op_in    : op_q;
  assign st_wide = accept ? wide     : wide_q;

  srot_step #(.DW(DATA_W)) u_step (
    .val     (st_val),
    .cin     (st_cin),
    .op      (st_op),
    .wide    (st_wide),
    .nval    (st_next),
    .cout    (st_cout),
    .msb_in  (msb_old),
    .msb_out (msb_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      cy_q   <= 1'b0;
      op_q   <= OP_ROL;
      wide_q <= 1'b0;
    end else if (accept) begin
      op_q   <= op_in;
      wide_q <= wide;
      work_q <= zero_cnt ? opnd_m : st_next;
      cy_q   <= zero_cnt ? carry_in : st_cout;
    end else if (busy) begin
      work_q <= st_next;
      cy_q   <= st_cout;
    end
  end

  srot_flags #(.DW(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin      (fin),
    .zero_cnt (zero_cnt),
    .single   (single),
    .shift_op (srot_is_shift(st_op)),
    .msb_old  (msb_old),
    .msb_new  (msb_new),
    .res      (st_next),
    .overflow (overflow),
    .sign     (sign),
    .zero     (zero),
    .parity   (parity)
  );

  assign result    = work_q;
  assign carry_out = cy_q;

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wide_q |-> result[DATA_W-1:HALF_W] == '0); // R6
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cnt |=> (result == $past(opnd_m)) && (carry_out == $past(carry_in))); // R10
  AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !accept |=> $stable({result, carry_out})); // R9

endmodule

// File: tb/srot_unit_tb.sv
module srot_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        wide = 1'b0;
  logic        use_count = 1'b0;
  logic [7:0]  count_val = 8'd0;
  logic [15:0] operand = 16'd0;
  logic        carry_in = 1'b0;
  logic        busy, done, carry_out, overflow, sign, zero, parity;
  logic [15:0] result;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic ov_m = 1'b0, s_m = 1'b0, z_m = 1'b0, p_m = 1'b0;

  srot_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .use_count(use_count), .count_val(count_val), .operand(operand),
    .carry_in(carry_in), .busy(busy), .done(done), .result(result),
    .carry_out(carry_out), .overflow(overflow), .sign(sign), .zero(zero),
    .parity(parity)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL R8 watchdog actual=%0d cycles expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input int opc);
    case (opc)
      0, 1:    return "R4";
      2, 3:    return "R5";
      5:       return "R2";
      7:       return "R3";
      default: return "R1";
    endcase
  endfunction

  // Behavioural model: the operand as a queue of bits, LSB at index 0.
  task automatic ref_run(input int opc, input bit wd, input int n, input logic [15:0] v,
                         input logic c, output logic [15:0] r, output logic co);
    bit q[$];
    bit b;
    int w;
    w = wd ? 16 : 8;
    co = c;
    for (int i = 0; i < w; i++) q.push_back(v[i]);
    for (int k = 0; k < n; k++) begin
      case (opc)
        0: begin b = q.pop_back();  co = b; q.push_front(b); end
        1: begin b = q.pop_front(); co = b; q.push_back(b); end
        2: begin b = q.pop_back();  q.push_front(co); co = b; end
        3: begin b = q.pop_front(); q.push_back(co);  co = b; end
        5: begin b = q.pop_front(); co = b; q.push_back(1'b0); end
        7: begin b = q.pop_front(); co = b; q.push_back(q[w-2]); end
        default: begin b = q.pop_back(); co = b; q.push_front(1'b0); end
      endcase
    end
    r = '0;
    for (int i = 0; i < w; i++) r[i] = q[i];
  endtask

  // Called at a falling edge; returns at the falling edge of the done cycle.
  task automatic run_op(input int opc, input bit wd, input bit sel, input int cval,
                        input logic [15:0] v, input logic c, input bit poke);
    int n, last, msb;
    logic [15:0] r;
    logic co;
    string t, rt, ft;
    n    = sel ? cval : 1;
    last = (n <= 1) ? 1 : n;
    msb  = wd ? 15 : 7;
    t    = op_tag(opc);
    op = 3'(opc); wide = wd; use_count = sel; count_val = 8'(cval);
    operand = v; carry_in = c; start = 1'b1;
    ref_run(opc, wd, n, v, c, r, co);
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 1'b0;
        if (poke && last > 2) begin
          start = 1'b1; operand = ~v; op = 3'(opc ^ 1);
          count_val = 8'd1; carry_in = ~c;
        end
      end else if (k == 2) begin
        start = 1'b0;
      end
      chk("R8 busy", int'(busy), int'(k < last));
      chk("R9 done", int'(done), int'(k == last));
    end
    if (n == 0) begin
      rt = "R10"; ft = "R10";
    end else begin
      rt = sel ? {t, "/R7"} : t;
      ft = "R12";
      ov_m = (n == 1) ? (r[msb] ^ v[msb]) : 1'b0;
      if (opc >= 4) begin
        s_m = r[msb];
        z_m = (r == 16'd0);
        p_m = ~^r[7:0];
      end
    end
    chk({rt, " result"}, int'(result), int'(r));
    chk({rt, " carry"}, int'(carry_out), int'(co));
    chk((n == 0) ? "R10 overflow" : "R11 overflow", int'(overflow), int'(ov_m));
    chk({ft, " sign"}, int'(sign), int'(s_m));
    chk({ft, " zero"}, int'(zero), int'(z_m));
    chk({ft, " parity"}, int'(parity), int'(p_m));
    if (!wd) chk("R6 upper byte", int'(result[15:8]), 0);
  endtask

  logic [15:0] pats [4] = '{16'h8F31, 16'h4C02, 16'h0080, 16'hFFFF};

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 result", int'(result), 0);
    chk("R13 carry", int'(carry_out), 0);
    chk("R13 busy", int'(busy), 0);
    chk("R13 done", int'(done), 0);
    chk("R13 flags", int'({overflow, sign, zero, parity}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int opc = 0; opc < 8; opc++) begin
      for (int wd = 0; wd < 2; wd++) begin
        run_op(opc, wd[0], 1'b0, 0, pats[(opc + wd) % 4], 1'((opc + wd) % 2), 1'b0);
        run_op(opc, wd[0], 1'b1, 0, pats[(opc + 1) % 4], 1'(opc % 2), 1'b0);
        run_op(opc, wd[0], 1'b1, 1, pats[(opc + 2) % 4], 1'((opc + 1) % 2), 1'b0);
        run_op(opc, wd[0], 1'b1, 5, pats[(opc + wd + 3) % 4], 1'(wd % 2), 1'b1);
        run_op(opc, wd[0], 1'b1, 19, pats[opc % 4], 1'b1, 1'b0);
      end
    end
    // zero result from a byte left shift: zero and overflow both set
    run_op(4, 1'b0, 1'b0, 0, 16'h1280, 1'b0, 1'b0);
    // long through-carry rotate with a conflicting start mid-way
    run_op(2, 1'b1, 1'b1, 255, 16'h1234, 1'b1, 1'b1);
    @(negedge clk);
    chk("R9 single-cycle done", int'(done), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule